// File: doc/BRIEF.md
# Clock-Synchronous Serial Byte Receiver

This block receives bytes over a two-wire synchronous serial link: one clock line and one data line. As master it produces the serial clock from the system clock through a programmable power-of-two divider. As slave it takes the serial clock from outside and brings both pins into the system clock domain through a synchronizer. Every rising serial-clock edge shifts one data bit into a shift register. After the eighth bit the byte moves into a receive buffer and a buffer-full flag goes high.

In master mode the clock runs without pause, so software receives a continuous stream as long as it empties the buffer each time the flag rises. A stop request lets the byte in progress finish, then parks the clock high. If a byte completes while the buffer is still full, the buffer keeps its older contents and an overrun flag is raised. The overrun flag stays set until it is cleared explicitly.

Top module: `sync_byte_rx`

## Requirements
- R1: Each data bit is sampled on a rising serial-clock edge, least significant bit first. The first sampled bit becomes bit 0 of the byte. After eight samples the byte appears on `rx_data_o` and `full_o` rises.
- R2: When enabled with `master_i`=1, the block drives the clock (`sclk_oe_o`=1). With `master_i`=0, `sclk_oe_o`=0 and `sclk_o` rests high. In that case `sclk_i` and `sdat_i` pass through a two-flop synchronizer, and rising edges of the synchronized clock are the sample points.
- R3: In master mode each serial-clock half period lasts 2^N system clocks, where N = `div_sel_i`.
- R4: In master mode without a stop request, clocking continues from one byte straight into the next with no idle gap.
- R5: A pulse on `stop_req_i` in master mode lets the current byte complete. After that, `sclk_o` stays high and no further edge is produced until `en_i` or `master_i` is dropped.
- R6: A pulse on `rd_i` clears `full_o`. If a byte completes in the same cycle, setting the flag wins.
- R7: If `full_o` is still 1 at the eighth rising edge of a new byte, `ovr_o` becomes 1 and `rx_data_o` keeps the earlier byte.
- R8: Only a pulse on `ovr_clr_i` (or dropping `en_i`) clears `ovr_o`. A buffer read leaves it set.
- R9: While `en_i`=0, the bit counter, shift register, buffer, `full_o` and `ovr_o` are cleared, `sclk_o`=1 and `sclk_oe_o`=0. A partly received byte is discarded.
- R10: After reset, `full_o`=0, `ovr_o`=0, `rx_data_o`=0, `sclk_o`=1 and `sclk_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receive enable |
| master_i | input | 1 | 1: generate serial clock, 0: accept it |
| div_sel_i | input | 4 | Master half period is 2^div_sel_i system clocks |
| stop_req_i | input | 1 | Pulse: stop after the byte in progress (master) |
| rd_i | input | 1 | Pulse: buffer has been read |
| ovr_clr_i | input | 1 | Pulse: clear overrun flag |
| sclk_i | input | 1 | Serial clock from outside (slave) |
| sdat_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock out, high when idle |
| sclk_oe_o | output | 1 | Output enable for serial clock pin |
| rx_data_o | output | 8 | Receive buffer |
| full_o | output | 1 | Buffer holds an unread byte |
| ovr_o | output | 1 | Byte lost because buffer was full |

## Verification
The hardest state to reach is an overrun. Reaching it takes two complete bytes with no read in between, while the first byte stays visible in the buffer. The bench turns off its automatic reader, clocks two slave-mode bytes back to back, and checks the buffer before and after the read. It then checks the overrun flag across a read and across its own clear pulse. The stop behaviour is also hard to observe: the bench raises the stop request in the middle of a master-mode byte, lets that byte finish, and counts clock-pin transitions over a long quiet window afterwards.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int BYTE_W  = 8;
  localparam int DIV_W   = 4;
  localparam int SYNC_N  = 2;
  localparam int BCNT_W  = $clog2(BYTE_W);
  localparam int HALF_W  = (1 << DIV_W) - 1;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= stg[STAGES-1];

  assign q_o    = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sbr_clkgen.sv
module sbr_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             stop_req_i,
  input  logic             byte_done_i,
  output logic             sclk_o,
  output logic             rise_o
);
  localparam int HALF_W = (1 << DIV_W) - 1;

  logic [HALF_W-1:0] div_cnt;
  logic [HALF_W-1:0] half_m1;
  logic              sclk_q, halted_q, pend_q;
  logic              run, tick;

  assign half_m1 = ~({HALF_W{1'b1}} << div_sel_i);
  assign run     = run_en_i && !halted_q;
  assign tick    = div_cnt >= half_m1;
  assign rise_o  = run && tick && !sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt  <= '0;
      sclk_q   <= 1'b1;
      halted_q <= 1'b0;
      pend_q   <= 1'b0;
    end else if (!run_en_i) begin
      div_cnt  <= '0;
      sclk_q   <= 1'b1;
      halted_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (stop_req_i && !halted_q) pend_q <= 1'b1;
      // stop lands on the rising edge that ends a byte, so the line parks high
      if (byte_done_i && (pend_q || stop_req_i)) begin
        halted_q <= 1'b1;
        pend_q   <= 1'b0;
      end
      if (run) begin
        if (tick) begin
          div_cnt <= '0;
          sclk_q  <= ~sclk_q;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
endmodule

// File: rtl/sbr_shift.sv
module sbr_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sample_i,
  input  logic              bit_i,
  input  logic              rd_i,
  input  logic              ovr_clr_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              byte_done_o
);
  localparam int BCNT_W = $clog2(BYTE_W);
  localparam logic [BCNT_W-1:0] LAST = BCNT_W'(BYTE_W - 1);

  logic [BCNT_W-1:0] bcnt;
  logic [BYTE_W-1:0] sh_q, sh_d, buf_q;
  logic              full_q, ovr_q;

  assign sh_d        = {bit_i, sh_q[BYTE_W-1:1]};
  assign byte_done_o = en_i && sample_i && (bcnt == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt   <= '0;
      sh_q   <= '0;
      buf_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (!en_i) begin
      bcnt   <= '0;
      sh_q   <= '0;
      buf_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (sample_i) begin
        sh_q <= sh_d;
        bcnt <= (bcnt == LAST) ? '0 : bcnt + 1'b1;
      end
      if (byte_done_o && !full_q) buf_q <= sh_d;
      if (byte_done_o && !full_q) full_q <= 1'b1;
      else if (rd_i)              full_q <= 1'b0;
      if (byte_done_o && full_q)  ovr_q <= 1'b1;
      else if (ovr_clr_i)         ovr_q <= 1'b0;
    end
  end

  assign data_o = buf_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/sync_byte_rx.sv
module sync_byte_rx
  import sbr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             master_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             stop_req_i,
  input  logic             rd_i,
  input  logic             ovr_clr_i,
  input  logic             sclk_i,
  input  logic             sdat_i,
  output logic             sclk_o,
  output logic             sclk_oe_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic             full_o,
  output logic             ovr_o
);
  logic [1:0] pin_q, pin_rise;
  logic       m_rise, sample, rx_bit, byte_done, m_run_en;

  sbr_sync #(.W(2), .STAGES(SYNC_N), .RST_VAL(2'b11)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sdat_i, sclk_i}),
    .q_o    (pin_q),
    .rise_o (pin_rise)
  );

  assign m_run_en = en_i && master_i;

  sbr_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_en_i    (m_run_en),
    .div_sel_i   (div_sel_i),
    .stop_req_i  (stop_req_i),
    .byte_done_i (byte_done),
    .sclk_o      (sclk_o),
    .rise_o      (m_rise)
  );

  assign sample = master_i ? m_rise : pin_rise[0];
  assign rx_bit = master_i ? sdat_i : pin_q[1];

  sbr_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .sample_i    (sample),
    .bit_i       (rx_bit),
    .rd_i        (rd_i),
    .ovr_clr_i   (ovr_clr_i),
    .data_o      (rx_data_o),
    .full_o      (full_o),
    .ovr_o       (ovr_o),
    .byte_done_o (byte_done)
  );

  assign sclk_oe_o = m_run_en;
endmodule

// File: rtl/sync_byte_rx_chk.sv
module sync_byte_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       rd_i,
  input logic       ovr_clr_i,
  input logic       sclk_o,
  input logic       sclk_oe_o,
  input logic [7:0] rx_data_o,
  input logic       full_o,
  input logic       ovr_o
);
  // R9
  en_off_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!full_o && !ovr_o && sclk_o));
  // R7
  ovr_keeps_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $stable(rx_data_o));
  // R6
  full_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> ($past(rd_i) || !$past(en_i)));
  // R8
  ovr_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovr_o) |-> ($past(ovr_clr_i) || !$past(en_i)));
  // R2
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_oe_o |-> sclk_o);
endmodule

bind sync_byte_rx sync_byte_rx_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .rd_i      (rd_i),
  .ovr_clr_i (ovr_clr_i),
  .sclk_o    (sclk_o),
  .sclk_oe_o (sclk_oe_o),
  .rx_data_o (rx_data_o),
  .full_o    (full_o),
  .ovr_o     (ovr_o)
);

// File: tb/sync_byte_rx_tb_top.sv
`timescale 1ns/1ps
module sync_byte_rx_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0, master_i = 1'b0;
  logic [3:0] div_sel_i = '0;
  logic       stop_req_i = 1'b0, ovr_clr_i = 1'b0;
  logic       man_rd = 1'b0, mon_rd = 1'b0, rd_i;
  logic       sclk_i = 1'b1, sdat_i = 1'b0;
  logic       sclk_o, sclk_oe_o, full_o, ovr_o;
  logic [7:0] rx_data_o;

  int n_cmp = 0, n_bad = 0, got = 0;
  bit auto_rd = 1'b0;
  logic [7:0] exp_q[$];

  assign rd_i = man_rd | mon_rd;
  always #10 clk_i = ~clk_i;

  sync_byte_rx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .master_i(master_i),
    .div_sel_i(div_sel_i), .stop_req_i(stop_req_i), .rd_i(rd_i),
    .ovr_clr_i(ovr_clr_i), .sclk_i(sclk_i), .sdat_i(sdat_i),
    .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o), .rx_data_o(rx_data_o),
    .full_o(full_o), .ovr_o(ovr_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // master driver: bench acts as sender, changes data after each falling edge
  task automatic m_drive(input logic [7:0] b);
    exp_q.push_back(b);
    for (int i = 0; i < 8; i++) begin
      @(negedge sclk_o);
      #1 sdat_i = b[i];
    end
  endtask

  task automatic s_bits(input logic [7:0] b, input int n, input int half);
    for (int i = 0; i < n; i++) begin
      sclk_i = 1'b0; sdat_i = b[i];
      cyc(half);
      sclk_i = 1'b1;
      cyc(half);
    end
  endtask

  task automatic s_drive(input logic [7:0] b, input int half, input bit push);
    if (push) exp_q.push_back(b);
    s_bits(b, 8, half);
    cyc(6);
  endtask

  // monitor: pops expected bytes when buffer fills, then reads it (R1, R6)
  initial begin
    forever begin
      @(negedge clk_i);
      if (auto_rd && full_o) begin
        if (exp_q.size() == 0) chk("R1 unexpected byte", rx_data_o, -1);
        else chk("R1 received byte", rx_data_o, exp_q.pop_front());
        got++;
        mon_rd = 1'b1;
        @(negedge clk_i);
        mon_rd = 1'b0;
        chk("R6 read clears full", full_o, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    real t0, t1;
    int  edges;
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    // R10
    chk("R10 full", full_o, 0);
    chk("R10 ovr", ovr_o, 0);
    chk("R10 data", rx_data_o, 0);
    chk("R10 sclk", sclk_o, 1);
    chk("R10 oe", sclk_oe_o, 0);

    // R4 continuous master stream, N=0
    auto_rd = 1'b1; got = 0; master_i = 1'b1; div_sel_i = 4'd0;
    fork begin m_drive(8'hA5); m_drive(8'h3C); m_drive(8'hF0); end join_none
    cyc(1);
    en_i = 1'b1;
    cyc(1);
    chk("R2 master drives clock", sclk_oe_o, 1);
    wait (got == 3);
    chk("R4 stream drained", exp_q.size(), 0);
    cyc(2);
    en_i = 1'b0;
    cyc(2);
    chk("R9 clock parked", sclk_o, 1);
    chk("R9 oe off", sclk_oe_o, 0);

    // R3 half period for N=2, then R5 stop during the byte
    got = 0; div_sel_i = 4'd2;
    fork m_drive(8'h81); join_none
    cyc(1);
    en_i = 1'b1;
    @(negedge sclk_o); t0 = $realtime;
    @(posedge sclk_o); t1 = $realtime;
    chk("R3 half period", int'((t1 - t0) / 20.0), 4);
    @(negedge clk_i);
    stop_req_i = 1'b1;
    @(negedge clk_i);
    stop_req_i = 1'b0;
    wait (got == 1);
    edges = 0;
    for (int i = 0; i < 120; i++) begin
      logic prev;
      prev = sclk_o;
      @(negedge clk_i);
      if (sclk_o !== prev) edges++;
    end
    chk("R5 no edges after stop", edges, 0);
    chk("R5 clock high", sclk_o, 1);
    chk("R5 no extra byte", full_o, 0);
    en_i = 1'b0;
    cyc(2);

    // R2 slave mode with synchronized pins, R1 ordering
    master_i = 1'b0; got = 0;
    en_i = 1'b1;
    cyc(2);
    chk("R2 slave oe", sclk_oe_o, 0);
    s_drive(8'h96, 6, 1'b1);
    s_drive(8'h01, 3, 1'b1);
    wait (got == 2);
    chk("R2 slave bytes", exp_q.size(), 0);

    // R7/R8 overrun
    auto_rd = 1'b0;
    s_drive(8'h5A, 4, 1'b0);
    chk("R1 full set", full_o, 1);
    chk("R1 data", rx_data_o, 8'h5A);
    s_drive(8'hC3, 4, 1'b0);
    chk("R7 ovr set", ovr_o, 1);
    chk("R7 old byte kept", rx_data_o, 8'h5A);
    man_rd = 1'b1; cyc(1); man_rd = 1'b0; cyc(1);
    chk("R6 full cleared", full_o, 0);
    chk("R8 ovr survives read", ovr_o, 1);
    ovr_clr_i = 1'b1; cyc(1); ovr_clr_i = 1'b0; cyc(1);
    chk("R8 ovr cleared", ovr_o, 0);

    // R9 disable discards partial byte and flags
    s_drive(8'h77, 4, 1'b0);
    s_drive(8'h11, 4, 1'b0);
    s_bits(8'hFF, 3, 4);
    cyc(4);
    en_i = 1'b0;
    cyc(2);
    chk("R9 full cleared", full_o, 0);
    chk("R9 ovr cleared", ovr_o, 0);
    chk("R9 data cleared", rx_data_o, 0);
    en_i = 1'b1; auto_rd = 1'b1; got = 0;
    cyc(2);
    s_drive(8'h24, 4, 1'b1);
    wait (got == 1);
    cyc(4);
    finish_run();
  end
endmodule